// File: doc/BRIEF.md
# Configurable I2S Serial Receiver

This block recovers stereo audio samples from a three-wire I2S stream: a bit clock, a word-select line and serial data. All three inputs are brought into the system clock domain through two-flop synchronizers. Rising bit-clock edges are found there by comparing the synchronized clock with its previous value. On each rising edge the block samples word select and serial data. It assembles one slot per channel, with the most significant bit first.

Two configuration inputs set the framing. `msb_shift` chooses between the one-bit-delay alignment, where the MSB follows the word-select change by one bit period, and the zero-delay alignment, where the MSB arrives together with the change. `right_first` states which channel opens a frame. Once both slots of a frame are complete, the left and right samples appear together on the parallel outputs with a single-cycle strobe. The system clock must run at least four times as fast as the bit clock.

Top module: `i2s_rx_deser`

## Requirements
- R1: After reset, `left_out` and `right_out` are zero and `pair_valid` is low.
- R2: Serial data is sampled on rising bit-clock edges, and the first bit of a slot lands in bit DW-1 of its sample.
- R3: With `msb_shift` = 0, the MSB of a slot is the bit sampled on the first rising edge at which word select holds its new value.
- R4: With `msb_shift` = 1, the MSB of a slot is the bit sampled one bit period after the rising edge that first sees the new word-select value.
- R5: A word-select level of 0 marks the left channel and 1 marks the right channel. With `right_first` = 1 a frame is the right slot followed by the left slot; with 0 it is left then right. Each sample always appears on its own channel's output.
- R6: `pair_valid` is high for exactly one system clock per frame. It rises only after the second slot of the frame has ended, which the next word-select boundary marks.
- R7: A slot with fewer than DW bits is delivered with its received bits in the top positions and zeros below them.
- R8: Bits that arrive in a slot after DW bits have been collected have no effect on the delivered sample.
- R9: After reset, all data is discarded until the first word-select transition. A frame whose first slot began before that transition is never delivered.
- R10: `left_out` and `right_out` change only in the cycle in which `pair_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bck_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Word select, 0 = left, 1 = right |
| sd_in | input | 1 | Serial data, MSB first |
| msb_shift | input | 1 | 1 = one-bit-delay alignment, 0 = zero-delay alignment |
| right_first | input | 1 | 1 = the right slot opens each frame |
| left_out | output | DW | Left sample of the last completed frame |
| right_out | output | DW | Right sample of the last completed frame |
| pair_valid | output | 1 | One-cycle strobe for a new sample pair |

## Verification
A bit counter that has gone wrong shows at the very next strobe as a sample shifted by some places, or as low bits that should be zero and are not. It never takes more than one frame to surface. If the channel tracking is wrong, or the block arms too early after reset, the output shows swapped samples, a missing pair or an extra pair within two slots. For this reason the bench compares every delivered pair and the total number of pairs against frames built arithmetically, for all four framing configurations.

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bck_in,
  input  logic          ws_in,
  input  logic          sd_in,
  input  logic          msb_shift,
  input  logic          right_first,
  output logic [DW-1:0] left_out,
  output logic [DW-1:0] right_out,
  output logic          pair_valid
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [DW-1:0] TOP = {1'b1, {(DW-1){1'b0}}};

  logic [2:0]    bck_p;
  logic [1:0]    ws_p, sd_p;
  logic          ws_d1, ws_d2;
  logic [1:0]    hv;
  logic [DW-1:0] shreg, hold;
  logic [CW-1:0] cnt;
  logic          armed, have_first;

  logic rise, sd_s, sel_ws, sel_prev, hist_ok, bnd, closing_first;
  assign rise          = bck_p[1] & ~bck_p[2];
  assign sd_s          = sd_p[1];
  assign sel_ws        = msb_shift ? ws_d1 : ws_p[1];
  assign sel_prev      = msb_shift ? ws_d2 : ws_d1;
  assign hist_ok       = msb_shift ? hv[1] : (hv != 2'd0);
  assign bnd           = rise & hist_ok & (sel_ws != sel_prev);
  assign closing_first = (sel_prev == right_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_p <= '0;
      ws_p  <= '0;
      sd_p  <= '0;
      ws_d1 <= 1'b0;
      ws_d2 <= 1'b0;
      hv    <= '0;
    end else begin
      bck_p <= {bck_p[1:0], bck_in};
      ws_p  <= {ws_p[0], ws_in};
      sd_p  <= {sd_p[0], sd_in};
      if (rise) begin
        ws_d1 <= ws_p[1];
        ws_d2 <= ws_d1;
        if (!hv[1]) hv <= hv + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      hold       <= '0;
      cnt        <= '0;
      armed      <= 1'b0;
      have_first <= 1'b0;
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (bnd) begin
        shreg <= sd_s ? TOP : '0;
        cnt   <= CW'(1);
        armed <= 1'b1;
        if (armed) begin
          if (closing_first) begin
            hold       <= shreg;
            have_first <= 1'b1;
          end else if (have_first) begin
            left_out   <= right_first ? shreg : hold;
            right_out  <= right_first ? hold : shreg;
            pair_valid <= 1'b1;
            have_first <= 1'b0;
          end
        end
      end else if (rise && cnt < CW'(DW)) begin
        if (sd_s) shreg <= shreg | (TOP >> cnt);
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

module i2s_rx_deser_chk #(
  parameter int DW = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pair_valid,
  input logic [DW-1:0] left_out,
  input logic [DW-1:0] right_out,
  input logic [CW-1:0] cnt,
  input logic          armed
);
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);
  assert_strobe_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> cnt == CW'(1));
  assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_out) && $stable(right_out)));
  assert_bit_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DW));
  assert_armed_before_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> armed);
endmodule

bind i2s_rx_deser i2s_rx_deser_chk #(.DW(DW), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
  .left_out(left_out), .right_out(right_out), .cnt(cnt), .armed(armed)
);

// File: tb/i2s_rx_deser_test.sv
module i2s_rx_deser_test;
  localparam int DW = 8;
  localparam int NF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic msb_shift = 1'b0, right_first = 1'b0;
  logic [DW-1:0] left_out, right_out;
  logic pair_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] got_l[$], got_r[$], exp_l[$], exp_r[$];
  logic chan_q[$], sd_q[$];
  logic [DW-1:0] last_l = '0, last_r = '0;
  logic last_v = 1'b0;
  int strobe_err = 0, hold_err = 0;

  always #4 clk = ~clk;

  i2s_rx_deser #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bck_in(bck), .ws_in(ws), .sd_in(sd),
    .msb_shift(msb_shift), .right_first(right_first),
    .left_out(left_out), .right_out(right_out), .pair_valid(pair_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (pair_valid) begin
        got_l.push_back(left_out);
        got_r.push_back(right_out);
        if (last_v) strobe_err++;
      end else if (left_out != last_l || right_out != last_r) begin
        hold_err++;
      end
    end
    last_v = pair_valid;
    last_l = left_out;
    last_r = right_out;
  end

  function automatic logic [DW-1:0] trunc(input logic [DW-1:0] v, input int len);
    if (len >= DW) return v;
    return v & (8'hFF << (DW - len));
  endfunction

  task automatic add_slot(input logic ch, input logic [DW-1:0] v, input int len);
    for (int i = 0; i < len; i++) begin
      chan_q.push_back(ch);
      sd_q.push_back(i < DW ? v[DW-1-i] : logic'(i[0]));
    end
  endtask

  task automatic play();
    for (int p = 0; p < chan_q.size(); p++) begin
      @(negedge clk);
      bck = 1'b0;
      ws = (msb_shift && p + 1 < chan_q.size()) ? chan_q[p+1] : chan_q[p];
      sd = sd_q[p];
      repeat (4) @(negedge clk);
      bck = 1'b1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    bck = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_cfg(input logic shift, input logic rf);
    string atag;
    logic [DW-1:0] vl, vr;
    int lf, ls;
    atag = shift ? "R4" : "R3";
    rst_n = 1'b0;
    bck = 1'b0; ws = rf; sd = 1'b0;
    msb_shift = shift; right_first = rf;
    got_l.delete(); got_r.delete(); exp_l.delete(); exp_r.delete();
    chan_q.delete(); sd_q.delete();
    repeat (3) @(negedge clk);
    check(left_out == 0 && right_out == 0 && pair_valid == 0, "R1 reset state",
          int'({left_out, right_out, pair_valid}), 0);
    rst_n = 1'b1;
    // R9: a partial first slot before the first transition, then a lone second slot
    add_slot(rf, 8'hA5, 3);
    add_slot(!rf, 8'h3C, DW);
    for (int k = 0; k < NF; k++) begin
      vl = 8'((k * 37 + 5) & 255);
      vr = 8'((k * 91 + 200) & 255);
      lf = (k == 3) ? 5 : (k == 6) ? 11 : DW;
      ls = (k == 4) ? 3 : (k == 7) ? 10 : DW;
      add_slot(rf, rf ? vr : vl, lf);
      add_slot(!rf, rf ? vl : vr, ls);
      exp_l.push_back(trunc(vl, rf ? ls : lf));
      exp_r.push_back(trunc(vr, rf ? lf : ls));
    end
    add_slot(rf, 8'h00, DW);
    add_slot(!rf, 8'h00, 2);
    play();
    check(got_l.size() == NF, "R9 R6 pair count", got_l.size(), NF);
    for (int k = 0; k < NF && k < got_l.size(); k++) begin
      string t;
      t = (k == 3 || k == 4) ? "R7 zero pad" : (k == 6 || k == 7) ? "R8 extra bits" : "R2 R5 sample";
      check(got_l[k] == exp_l[k], {atag, " ", t, " left"}, got_l[k], exp_l[k]);
      check(got_r[k] == exp_r[k], {atag, " ", t, " right"}, got_r[k], exp_r[k]);
    end
  endtask

  initial begin
    run_cfg(1'b0, 1'b0);
    run_cfg(1'b0, 1'b1);
    run_cfg(1'b1, 1'b0);
    run_cfg(1'b1, 1'b1);
    check(strobe_err == 0, "R6 strobe width", strobe_err, 0);
    check(hold_err == 0, "R10 outputs hold", hold_err, 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule